// File: doc/BRIEF.md
# Response Check and Completion Interrupt Unit

This unit sits inside a storage-card host controller, between the receive logic that delivers decoded command responses and end-of-busy packets and the interrupt status register seen by software. For each accepted response it can judge the card status word against a fixed set of error bits, chosen for a memory response or an SDIO response. It raises command complete unless the response interrupt has been turned off. The host driver can therefore hand routine status checking to the hardware.

When a command is issued with busy-wait enabled, the unit arms a pending-busy state. The next end-of-busy packet retires that state and raises transfer complete. If the packet carries an error, the end-of-busy error flag and the summary error flag are raised in the same cycle as transfer complete. All status flags are sticky and are cleared by writing one to the matching bit. Responses and end-of-busy packets arrive on valid/ready streams. The unit never applies back-pressure: ready is held high, so a transfer completes in every cycle where valid is high. Control and status pins are plain levels.

Top module: `resp_done_irq`

## Requirements
- R1: With checking enabled and the type select at 0 (memory), an accepted response raises the response error flag (status bit 2) exactly when any of word bits 31, 30, 29, 26, 25, 23, 21, 20 or 19 is 1.
- R2: With checking enabled and the type select at 1 (SDIO), an accepted response raises the response error flag exactly when any of word bits 7, 3, 1 or 0 is 1.
- R3: With checking disabled, no response raises the response error flag, whatever its word.
- R4: An accepted response raises command complete (status bit 0) on the next clock edge unless the response interrupt disable input is 1, in which case command complete stays clear.
- R5: A command start with busy-wait at 1 arms a pending busy. The next accepted end-of-busy packet raises transfer complete (status bit 1) and retires the pending state.
- R6: An end-of-busy packet arriving with no busy pending changes no flag. This covers a command started with busy-wait at 0 and a second packet after the first has retired the pending state.
- R7: An end-of-busy packet with its error bit set, arriving while busy is pending, raises end-of-busy error (status bit 3), summary error (status bit 4) and transfer complete on the same clock edge.
- R8: A response error also raises the summary error flag on the same edge.
- R9: Each status flag stays 1 until a write-one-to-clear pulse on its own bit. A set event in the same cycle as that clear wins, and the flag stays 1.
- R10: After reset all five status flags read 0.
- R11: Both stream ready outputs stay 1, so every valid cycle is one accepted item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rsp_valid | input | 1 | Response word is offered |
| rsp_ready | output | 1 | Response accepted (always 1) |
| rsp_word | input | 32 | Card status field of the response |
| eob_valid | input | 1 | End-of-busy packet is offered |
| eob_ready | output | 1 | End-of-busy accepted (always 1) |
| eob_err | input | 1 | End-of-busy packet reports an error |
| cmd_start | input | 1 | One-cycle pulse when a command is issued |
| cfg_busy_wait | input | 1 | Command waits for an end-of-busy packet |
| cfg_rsp_irq_off | input | 1 | Suppress command complete |
| cfg_chk_en | input | 1 | Hardware response error check enable |
| cfg_sdio | input | 1 | Mask select: 1 SDIO, 0 memory |
| stat_clr | input | 5 | Write-one-to-clear pulses, one per flag |
| stat_flags | output | 5 | {sum_err, eob_err, rsp_err, xfer_done, cmd_done} |

## Verification
The pending-busy bit is the only hidden state. If it is stuck clear, the first armed end-of-busy packet leaves transfer complete low one edge later. If it is stuck set, or never retires, a stray packet raises transfer complete where R6 forbids it, again on the next edge. A wrong mask bit or a lost set-over-clear priority shows on the status flags one edge after the response or clear cycle. Each scenario therefore samples the flags immediately after the edge that consumes its stimulus.

// File: rtl/resp_done_pkg.sv
package resp_done_pkg;
  localparam int NFLAG = 5;
  localparam int F_CMD  = 0;
  localparam int F_XFER = 1;
  localparam int F_RSP  = 2;
  localparam int F_EOB  = 3;
  localparam int F_SUM  = 4;

  typedef logic [NFLAG-1:0] flag_vec_t;

  typedef struct packed {
    logic busy_wait;
    logic rsp_irq_off;
    logic chk_en;
    logic sdio;
  } ctrl_t;
endpackage

// File: rtl/resp_judge.sv
module resp_judge #(
  parameter int          W        = 32,
  parameter logic [W-1:0] MEM_MASK = 32'hE6B8_0000,
  parameter logic [W-1:0] IO_MASK  = 32'h0000_008B
) (
  input  logic         fire,
  input  logic [W-1:0] word,
  input  logic         chk_en,
  input  logic         sdio,
  output logic         err_hit
);
  logic [W-1:0] sel_mask;
  always_comb begin
    sel_mask = sdio ? IO_MASK : MEM_MASK;
    err_hit  = fire && chk_en && ((word & sel_mask) != '0);
  end
endmodule

// File: rtl/busy_track.sv
module busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic busy_wait,
  input  logic eob_fire,
  input  logic eob_err,
  output logic pend,
  output logic done_hit,
  output logic err_hit
);
  always_comb begin
    done_hit = pend && eob_fire;
    err_hit  = done_hit && eob_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (cmd_start && busy_wait) || (pend && !eob_fire);
  end
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags[i] <= 1'b0;
      else if (set_i[i]) flags[i] <= 1'b1;
      else if (clr_i[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/resp_done_irq.sv
module resp_done_irq
  import resp_done_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [W-1:0]     rsp_word,
  input  logic             eob_valid,
  output logic             eob_ready,
  input  logic             eob_err,
  input  logic             cmd_start,
  input  logic             cfg_busy_wait,
  input  logic             cfg_rsp_irq_off,
  input  logic             cfg_chk_en,
  input  logic             cfg_sdio,
  input  logic [NFLAG-1:0] stat_clr,
  output logic [NFLAG-1:0] stat_flags
);
  ctrl_t     ctrl;
  flag_vec_t set_vec;
  logic      rsp_fire, eob_fire, rsp_bad, busy_pend, eob_done, eob_bad;

  assign rsp_ready = 1'b1;
  assign eob_ready = 1'b1;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign eob_fire  = eob_valid && eob_ready;

  always_comb begin
    ctrl.busy_wait   = cfg_busy_wait;
    ctrl.rsp_irq_off = cfg_rsp_irq_off;
    ctrl.chk_en      = cfg_chk_en;
    ctrl.sdio        = cfg_sdio;
  end

  resp_judge #(.W(W)) u_judge (
    .fire(rsp_fire), .word(rsp_word), .chk_en(ctrl.chk_en),
    .sdio(ctrl.sdio), .err_hit(rsp_bad)
  );

  busy_track u_busy (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start),
    .busy_wait(ctrl.busy_wait), .eob_fire(eob_fire), .eob_err(eob_err),
    .pend(busy_pend), .done_hit(eob_done), .err_hit(eob_bad)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[F_CMD]  = rsp_fire && !ctrl.rsp_irq_off;
    set_vec[F_XFER] = eob_done;
    set_vec[F_RSP]  = rsp_bad;
    set_vec[F_EOB]  = eob_bad;
    set_vec[F_SUM]  = rsp_bad || eob_bad;
  end

  flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(stat_clr),
    .flags(stat_flags)
  );
endmodule

// File: rtl/resp_done_irq_chk.sv
module resp_done_irq_chk
  import resp_done_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rsp_valid,
  input logic             eob_valid,
  input logic             cfg_rsp_irq_off,
  input logic             cfg_chk_en,
  input logic             busy_pend,
  input logic             rsp_ready,
  input logic             eob_ready,
  input logic [NFLAG-1:0] stat_clr,
  input logic [NFLAG-1:0] stat_flags
);
  AST_CC_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_flags[F_CMD] && cfg_rsp_irq_off) |=> !stat_flags[F_CMD]); // R4

  AST_NO_CHECK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_flags[F_RSP] && !cfg_chk_en) |=> !stat_flags[F_RSP]); // R3

  AST_XFER_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_flags[F_XFER]) |-> ($past(busy_pend) && $past(eob_valid))); // R6

  AST_EOB_ERR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_flags[F_EOB]) |-> (stat_flags[F_SUM] && stat_flags[F_XFER])); // R7

  AST_RSP_ERR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_flags[F_RSP]) |-> stat_flags[F_SUM]); // R8

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_flags) & ~$past(stat_clr)) & ~stat_flags) == '0)); // R9

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready && eob_ready); // R11
endmodule

bind resp_done_irq resp_done_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .eob_valid(eob_valid),
  .cfg_rsp_irq_off(cfg_rsp_irq_off), .cfg_chk_en(cfg_chk_en),
  .busy_pend(busy_pend), .rsp_ready(rsp_ready), .eob_ready(eob_ready),
  .stat_clr(stat_clr), .stat_flags(stat_flags)
);

// File: tb/resp_done_irq_bench.sv
module resp_done_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rsp_valid = 1'b0, eob_valid = 1'b0, eob_err = 1'b0, cmd_start = 1'b0;
  logic [31:0] rsp_word = '0;
  logic        cfg_busy_wait = 1'b0, cfg_rsp_irq_off = 1'b0, cfg_chk_en = 1'b0, cfg_sdio = 1'b0;
  logic [4:0]  stat_clr = '0;
  logic        rsp_ready, eob_ready;
  logic [4:0]  stat_flags;
  int          n_chk = 0, n_err = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  resp_done_irq u_resp_done_irq (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_word(rsp_word), .eob_valid(eob_valid), .eob_ready(eob_ready),
    .eob_err(eob_err), .cmd_start(cmd_start), .cfg_busy_wait(cfg_busy_wait),
    .cfg_rsp_irq_off(cfg_rsp_irq_off), .cfg_chk_en(cfg_chk_en), .cfg_sdio(cfg_sdio),
    .stat_clr(stat_clr), .stat_flags(stat_flags)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); stat_clr = 5'h1F;
    @(negedge clk); stat_clr = '0;
  endtask

  task automatic send_rsp(logic [31:0] w);
    @(negedge clk); rsp_valid = 1'b1; rsp_word = w;
    @(negedge clk); rsp_valid = 1'b0;
  endtask

  task automatic send_eob(logic e);
    @(negedge clk); eob_valid = 1'b1; eob_err = e;
    @(negedge clk); eob_valid = 1'b0; eob_err = 1'b0;
  endtask

  task automatic start_cmd(logic bw);
    @(negedge clk); cmd_start = 1'b1; cfg_busy_wait = bw;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 reset flags", {27'd0, stat_flags}, 32'd0);
    check("R11 ready", {30'd0, rsp_ready, eob_ready}, 32'd3);
  endtask

  task automatic t_mem_mask();
    cfg_chk_en = 1'b1; cfg_sdio = 1'b0;
    for (int b = 0; b < 32; b++) begin
      logic hit;
      hit = (b == 31) || (b == 30) || (b == 29) || (b == 26) || (b == 25) ||
            (b == 23) || (b == 21) || (b == 20) || (b == 19);
      send_rsp(32'd1 << b);
      check("R1 mem bit", {27'd0, stat_flags}, hit ? 32'h15 : 32'h01);
      clear_all();
    end
  endtask

  task automatic t_sdio_mask();
    cfg_chk_en = 1'b1; cfg_sdio = 1'b1;
    for (int b = 0; b < 32; b++) begin
      logic hit;
      hit = (b == 7) || (b == 3) || (b == 1) || (b == 0);
      send_rsp(32'd1 << b);
      check("R2 sdio bit", {27'd0, stat_flags}, hit ? 32'h15 : 32'h01);
      clear_all();
    end
    send_rsp(32'hFFFF_FF74);
    check("R2 sdio clean rest", {27'd0, stat_flags}, 32'h01);
    clear_all();
  endtask

  task automatic t_chk_off();
    cfg_chk_en = 1'b0; cfg_sdio = 1'b0;
    send_rsp(32'hFFFF_FFFF);
    check("R3 check off", {27'd0, stat_flags}, 32'h01);
    clear_all();
  endtask

  task automatic t_irq_off();
    cfg_rsp_irq_off = 1'b1; cfg_chk_en = 1'b1; cfg_sdio = 1'b0;
    send_rsp(32'h0000_0000);
    check("R4 cc suppressed", {27'd0, stat_flags}, 32'h00);
    send_rsp(32'h8000_0000);
    check("R4 R8 err w/o cc", {27'd0, stat_flags}, 32'h14);
    cfg_rsp_irq_off = 1'b0;
    clear_all();
    send_rsp(32'h0);
    check("R4 cc raised", {27'd0, stat_flags}, 32'h01);
    clear_all();
  endtask

  task automatic t_busy();
    start_cmd(1'b1);
    check("R5 no early xfer", {27'd0, stat_flags}, 32'h00);
    send_eob(1'b0);
    check("R5 xfer done", {27'd0, stat_flags}, 32'h02);
    clear_all();
    send_eob(1'b1);
    check("R6 second eob ignored", {27'd0, stat_flags}, 32'h00);
    start_cmd(1'b0);
    send_eob(1'b1);
    check("R6 no busy wait", {27'd0, stat_flags}, 32'h00);
    cfg_busy_wait = 1'b0;
  endtask

  task automatic t_eob_err();
    start_cmd(1'b1);
    send_eob(1'b1);
    check("R7 eob err set", {27'd0, stat_flags}, 32'h1A);
    clear_all();
    cfg_busy_wait = 1'b0;
  endtask

  task automatic t_sticky();
    cfg_chk_en = 1'b1; cfg_sdio = 1'b1;
    send_rsp(32'h0000_0080);
    repeat (3) @(negedge clk);
    check("R9 held", {27'd0, stat_flags}, 32'h15);
    @(negedge clk); stat_clr = 5'b00010;
    @(negedge clk); stat_clr = '0;
    check("R9 other clear", {27'd0, stat_flags}, 32'h15);
    @(negedge clk); stat_clr = 5'b00001;
    @(negedge clk); stat_clr = '0;
    check("R9 clear one", {27'd0, stat_flags}, 32'h14);
    @(negedge clk); stat_clr = 5'h1F; rsp_valid = 1'b1; rsp_word = 32'h0000_0001;
    @(negedge clk); stat_clr = '0; rsp_valid = 1'b0;
    check("R9 set beats clear", {27'd0, stat_flags}, 32'h15);
    clear_all();
    check("R9 all cleared", {27'd0, stat_flags}, 32'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mem_mask();
    t_sdio_mask();
    t_chk_off();
    t_irq_off();
    t_busy();
    t_eob_err();
    t_sticky();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule